// File: doc/BRIEF.md
# Range-Matching Translation Cache

This block is a small, fully associative cache of completed address translations. Each stored entry covers a naturally aligned region of virtual address space. The size of that region comes from three fill-time inputs: the translation granule, the lookup level the walk finished at, and a contiguous-hint bit. When the hint is set, one entry stands for a fixed run of adjacent descriptors, so it covers a larger region. The run length depends on the granule and the level. The set of region sizes is small and shared between the granules, so the match logic only handles eight distinct sizes.

A lookup presents a virtual address. Every entry compares the address bits above its own region size. The registered result appears on the next clock: a hit flag, the physical address and the stored attributes. The physical address takes its upper bits from the entry and its lower bits straight from the virtual address. Fills are written into the slots in round-robin order. A single invalidate input empties the cache in one cycle. When more than one entry matches, the lowest-numbered slot supplies the result and a multi-match flag is raised.

Top module: `tlbc_top`

## Requirements
- R1: After reset, hit_o, multi_o, pa_o and attr_o are 0 and every slot is empty, so any lookup misses.
- R2: The result of a lookup accepted on clock edge N is visible after edge N+1. In any cycle following one without lk_valid, hit_o and multi_o are 0.
- R3: With granule code 0 (4KB), levels 1, 2 and 3 cover 1GB, 2MB and 4KB. With the contiguous bit set they cover 16GB, 32MB and 64KB.
- R4: With granule code 1 (16KB), level 2 covers 32MB and level 3 covers 16KB. With the contiguous bit set they cover 1GB and 2MB.
- R5: With granule code 2 (64KB), level 2 covers 512MB and level 3 covers 64KB. With the contiguous bit set they cover 16GB and 2MB.
- R6: Level codes are 1, 2 and 3. A fill is dropped, with no slot written and the replacement pointer unchanged, in any of these cases: granule code 3, level code 0, or level 1 with a granule other than 4KB.
- R7: A fill stores its virtual and physical addresses aligned down to the region size. A lookup hits when the address bits at and above log2(size) are equal. On a hit, pa_o equals the stored physical base OR the virtual bits below log2(size).
- R8: Accepted fills go to slots 0, 1, 2 and so on up to 7, then wrap back to 0. The ninth fill replaces the first entry.
- R9: inv_all empties every slot in one cycle and resets the replacement pointer to slot 0. If a fill arrives in the same cycle, inv_all wins and the fill is discarded.
- R10: When several slots match, the lowest-numbered one supplies pa_o and attr_o, and multi_o is 1. With a single match, multi_o is 0.
- R11: On a hit, attr_o returns the attributes stored by the fill of the matching slot. On a miss, pa_o and attr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| fill_valid | input | 1 | Install request |
| fill_va | input | VA_W | Virtual address of the new entry |
| fill_pa | input | PA_W | Physical address of the new entry |
| fill_attr | input | ATTR_W | Attributes of the new entry |
| fill_gran | input | 2 | Granule code: 0 is 4KB, 1 is 16KB, 2 is 64KB |
| fill_level | input | 2 | Lookup level, 1 to 3 |
| fill_contig | input | 1 | Contiguous hint |
| inv_all | input | 1 | Invalidate every slot |
| hit_o | output | 1 | Registered hit flag |
| multi_o | output | 1 | Registered multi-match flag |
| pa_o | output | PA_W | Registered physical address |
| attr_o | output | ATTR_W | Registered attributes |

## Verification
Some properties hold on every cycle, and the assertions check those. The cache is silent when idle and clears at reset. A multi-match never appears without a hit. The low twelve physical address bits always pass through from the virtual address. The first lookup after an invalidate always misses. Other behaviour is only visible over a scenario, so the bench covers it. This includes the region size for each granule, level and hint combination, and the discarding of illegal fills. It also includes the wrap of the round-robin pointer and the lowest-slot rule when an entry overlaps another. The bench checks these against a reference model that runs random fills and lookups biased toward hits.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
  localparam int SHIFT_W = 6;

  // Returns {legal, log2(region size)} for a granule/level/hint triple.
  function automatic logic [SHIFT_W:0] region_shift(input logic [1:0] gran,
                                                    input logic [1:0] lvl,
                                                    input logic       contig);
    logic [SHIFT_W-1:0] sh;
    logic               ok;
    sh = '0;
    ok = 1'b1;
    unique case ({gran, lvl})
      4'b00_01: sh = contig ? 6'd34 : 6'd30;
      4'b00_10: sh = contig ? 6'd25 : 6'd21;
      4'b00_11: sh = contig ? 6'd16 : 6'd12;
      4'b01_10: sh = contig ? 6'd30 : 6'd25;
      4'b01_11: sh = contig ? 6'd21 : 6'd14;
      4'b10_10: sh = contig ? 6'd34 : 6'd29;
      4'b10_11: sh = contig ? 6'd21 : 6'd16;
      default:  ok = 1'b0;
    endcase
    return {ok, sh};
  endfunction
endpackage

// File: rtl/tlbc_entry.sv
module tlbc_entry #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int ATTR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         wr,
  input  logic [VA_W-1:0]              wr_va,
  input  logic [PA_W-1:0]              wr_pa,
  input  logic [ATTR_W-1:0]            wr_attr,
  input  logic [tlbc_pkg::SHIFT_W-1:0] wr_shift,
  input  logic [VA_W-1:0]              lk_va,
  output logic                         match,
  output logic [PA_W-1:0]              pa_out,
  output logic [ATTR_W-1:0]            attr_out
);
  logic                         vld;
  logic [VA_W-1:0]              tag_va;
  logic [PA_W-1:0]              tag_pa;
  logic [ATTR_W-1:0]            tag_attr;
  logic [tlbc_pkg::SHIFT_W-1:0] tag_sh;

  logic [VA_W-1:0] wmask_va, mask_va;
  logic [PA_W-1:0] wmask_pa, mask_pa;

  always_comb begin
    wmask_va = {VA_W{1'b1}} << wr_shift;
    wmask_pa = {PA_W{1'b1}} << wr_shift;
    mask_va  = {VA_W{1'b1}} << tag_sh;
    mask_pa  = {PA_W{1'b1}} << tag_sh;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= 1'b0;
    end else if (wr) begin
      vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) begin
      tag_va   <= wr_va & wmask_va;
      tag_pa   <= wr_pa & wmask_pa;
      tag_attr <= wr_attr;
      tag_sh   <= wr_shift;
    end
  end

  always_comb begin
    match    = vld && (((lk_va ^ tag_va) & mask_va) == '0);
    pa_out   = tag_pa | (PA_W'(lk_va) & ~mask_pa);
    attr_out = tag_attr;
  end
endmodule

// File: rtl/tlbc_pick.sv
module tlbc_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]         hits,
  output logic                 any,
  output logic                 multi,
  output logic [$clog2(N)-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = i[$clog2(N)-1:0];
    end
    any   = |hits;
    multi = $countones(hits) > 1;
  end
endmodule

// File: rtl/tlbc_top.sv
module tlbc_top #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int ATTR_W  = 8,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              fill_valid,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [1:0]        fill_gran,
  input  logic [1:0]        fill_level,
  input  logic              fill_contig,
  input  logic              inv_all,
  output logic              hit_o,
  output logic              multi_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [tlbc_pkg::SHIFT_W:0]   dec;
  logic                         fill_ok;
  logic [tlbc_pkg::SHIFT_W-1:0] fill_sh;
  logic [IDX_W-1:0]             wr_ptr;
  logic [ENTRIES-1:0]           hits;
  logic [PA_W-1:0]              e_pa   [ENTRIES];
  logic [ATTR_W-1:0]            e_attr [ENTRIES];
  logic                         any_hit, many_hit;
  logic [IDX_W-1:0]             sel;
  logic                         do_fill;

  always_comb begin
    dec     = tlbc_pkg::region_shift(fill_gran, fill_level, fill_contig);
    fill_ok = dec[tlbc_pkg::SHIFT_W];
    fill_sh = dec[tlbc_pkg::SHIFT_W-1:0];
    do_fill = fill_valid && fill_ok && !inv_all;
  end

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      wr_ptr <= '0;
    end else if (do_fill) begin
      wr_ptr <= (wr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlbc_entry #(.VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W)) u_ent (
      .clk      (clk),
      .rst      (rst),
      .clr      (inv_all),
      .wr       (do_fill && (wr_ptr == IDX_W'(g))),
      .wr_va    (fill_va),
      .wr_pa    (fill_pa),
      .wr_attr  (fill_attr),
      .wr_shift (fill_sh),
      .lk_va    (lk_va),
      .match    (hits[g]),
      .pa_out   (e_pa[g]),
      .attr_out (e_attr[g])
    );
  end

  tlbc_pick #(.N(ENTRIES)) u_pick (
    .hits  (hits),
    .any   (any_hit),
    .multi (many_hit),
    .idx   (sel)
  );

  always_ff @(posedge clk) begin
    if (rst || !lk_valid || !any_hit) begin
      hit_o   <= 1'b0;
      multi_o <= 1'b0;
      pa_o    <= '0;
      attr_o  <= '0;
    end else begin
      hit_o   <= 1'b1;
      multi_o <= many_hit;
      pa_o    <= e_pa[sel];
      attr_o  <= e_attr[sel];
    end
  end
endmodule

// File: rtl/tlbc_checker.sv
module tlbc_checker #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int ATTR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_va,
  input logic              inv_all,
  input logic              hit_o,
  input logic              multi_o,
  input logic [PA_W-1:0]   pa_o,
  input logic [ATTR_W-1:0] attr_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!hit_o && !multi_o && pa_o == '0 && attr_o == '0)); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!hit_o && !multi_o)); // R2
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!hit_o || pa_o[11:0] == $past(lk_va[11:0]))); // R7
  AST_INV_MISS: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !rst) |=> (lk_valid |=> !hit_o)); // R9
  AST_MULTI_HIT: assert property (@(posedge clk) disable iff (rst)
    multi_o |-> hit_o); // R10
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (pa_o == '0 && attr_o == '0)); // R11
endmodule

bind tlbc_top tlbc_checker #(.VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .inv_all(inv_all),
  .hit_o(hit_o), .multi_o(multi_o), .pa_o(pa_o), .attr_o(attr_o)
);

// File: tb/tb_tlbc_top.sv
module tb_tlbc_top;
  localparam int VA_W = 48, PA_W = 48, ATTR_W = 8, N = 8;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, fill_valid = 0, fill_contig = 0, inv_all = 0;
  logic [VA_W-1:0] lk_va = '0, fill_va = '0;
  logic [PA_W-1:0] fill_pa = '0;
  logic [ATTR_W-1:0] fill_attr = '0;
  logic [1:0] fill_gran = '0, fill_level = '0;
  logic hit_o, multi_o;
  logic [PA_W-1:0] pa_o;
  logic [ATTR_W-1:0] attr_o;

  int checks = 0, fails = 0;

  // reference model
  logic            m_vld [N];
  logic [VA_W-1:0] m_va  [N];
  logic [PA_W-1:0] m_pa  [N];
  logic [ATTR_W-1:0] m_at [N];
  int              m_sh  [N];
  int              m_ptr;

  always #2.5 clk = ~clk;

  tlbc_top #(.VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W), .ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .fill_valid(fill_valid), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_attr(fill_attr), .fill_gran(fill_gran), .fill_level(fill_level),
    .fill_contig(fill_contig), .inv_all(inv_all), .hit_o(hit_o),
    .multi_o(multi_o), .pa_o(pa_o), .attr_o(attr_o));

  // Region size from the requirements R3/R4/R5; -1 marks an illegal fill (R6).
  function automatic int ref_shift(input int g, input int l, input bit c);
    case (g)
      0: case (l) 1: return c ? 34 : 30; 2: return c ? 25 : 21; 3: return c ? 16 : 12; default: return -1; endcase
      1: case (l) 2: return c ? 30 : 25; 3: return c ? 21 : 14; default: return -1; endcase
      2: case (l) 2: return c ? 34 : 29; 3: return c ? 21 : 16; default: return -1; endcase
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] lowmask(input int sh);
    return (64'd1 << sh) - 64'd1;
  endfunction

  function automatic logic [VA_W-1:0] rnd_va();
    return VA_W'({$urandom(), $urandom()});
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_ptr = 0;
  endtask

  task automatic do_fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                         input logic [ATTR_W-1:0] at, input int g, input int l,
                         input bit c, input bit inv);
    int sh;
    @(negedge clk);
    fill_valid = 1; fill_va = va; fill_pa = pa; fill_attr = at;
    fill_gran = 2'(g); fill_level = 2'(l); fill_contig = c; inv_all = inv;
    @(negedge clk);
    fill_valid = 0; inv_all = 0;
    sh = ref_shift(g, l, c);
    if (inv) model_reset();
    else if (sh >= 0) begin
      m_vld[m_ptr] = 1;
      m_va[m_ptr]  = va & ~VA_W'(lowmask(sh));
      m_pa[m_ptr]  = pa & ~PA_W'(lowmask(sh));
      m_at[m_ptr]  = at;
      m_sh[m_ptr]  = sh;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic do_inv();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    model_reset();
  endtask

  task automatic do_lookup(input logic [VA_W-1:0] va, input string req);
    bit eh = 0, em = 0;
    logic [PA_W-1:0] ep = '0;
    logic [ATTR_W-1:0] ea = '0;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && (((va ^ m_va[i]) & ~VA_W'(lowmask(m_sh[i]))) == '0)) begin
        if (eh) em = 1;
        else begin
          eh = 1;
          ep = m_pa[i] | (PA_W'(va) & PA_W'(lowmask(m_sh[i])));
          ea = m_at[i];
        end
      end
    end
    @(negedge clk); lk_valid = 1; lk_va = va;
    @(negedge clk); lk_valid = 0;
    check({req, " hit"}, 64'(hit_o), 64'(eh));
    check({req, " multi"}, 64'(multi_o), 64'(em));
    check({req, " pa"}, 64'(pa_o), 64'(ep));
    check({req, " attr R11"}, 64'(attr_o), 64'(ea));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7715));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 hit", 64'(hit_o), 0);
    check("R1 pa", 64'(pa_o), 0);
    do_lookup(48'h0000_1234_5678, "R1 empty lookup");
    // R2: idle cycle after a lookup
    @(negedge clk);
    check("R2 idle hit", 64'(hit_o), 0);

    // R3: 4KB granule, every level and hint
    for (int l = 1; l <= 3; l++) for (int c = 0; c <= 1; c++) begin
      logic [VA_W-1:0] va = rnd_va();
      do_inv();
      do_fill(va, PA_W'({$urandom(), $urandom()}), 8'(l * 2 + c), 0, l, c[0], 0);
      do_lookup(va ^ VA_W'(lowmask(ref_shift(0, l, c[0]))), "R3 top of region");
      do_lookup(va ^ (VA_W'(1) << ref_shift(0, l, c[0])), "R3 next region");
    end
    // R4 / R5: 16KB and 64KB granules
    for (int g = 1; g <= 2; g++) for (int l = 2; l <= 3; l++) for (int c = 0; c <= 1; c++) begin
      logic [VA_W-1:0] va = rnd_va();
      do_inv();
      do_fill(va, PA_W'({$urandom(), $urandom()}), 8'(g), g, l, c[0], 0);
      do_lookup(va ^ VA_W'(lowmask(ref_shift(g, l, c[0]))), g == 1 ? "R4 inside" : "R5 inside");
      do_lookup(va ^ (VA_W'(1) << ref_shift(g, l, c[0])), g == 1 ? "R4 outside" : "R5 outside");
    end

    // R6: illegal fills dropped, pointer unchanged
    do_inv();
    do_fill(48'h0000_0040_0000, 48'h0000_0080_0000, 8'h11, 1, 1, 0, 0);
    do_fill(48'h0000_0040_0000, 48'h0000_0080_0000, 8'h12, 3, 3, 0, 0);
    do_fill(48'h0000_0040_0000, 48'h0000_0080_0000, 8'h13, 0, 0, 0, 0);
    do_lookup(48'h0000_0040_0000, "R6 illegal dropped");

    // R8: nine fills, ninth replaces slot 0
    for (int i = 0; i < 9; i++)
      do_fill(VA_W'(i) << 12, 48'h0000_7000_0000 + (PA_W'(i) << 12), 8'(i), 0, 3, 0, 0);
    do_lookup(48'h0, "R8 wrapped slot0 old 4KB page");
    do_lookup(48'h0000_0000_8000, "R8 ninth entry");
    do_lookup(48'h0000_0000_1abc, "R8 second entry kept");

    // R10: overlapping entries, lowest slot wins
    do_inv();
    do_fill(48'h0000_0020_0000, 48'h0000_0a00_0000, 8'hA0, 0, 2, 0, 0);
    do_fill(48'h0000_0020_3000, 48'h0000_0b00_0000, 8'hB0, 0, 3, 0, 0);
    do_lookup(48'h0000_0020_3456, "R10 overlap");
    do_lookup(48'h0000_0021_0000, "R10 single");

    // R9: invalidate beats a same-cycle fill
    do_fill(48'h0000_0030_0000, 48'h0, 8'hC0, 0, 3, 0, 1);
    do_lookup(48'h0000_0020_3456, "R9 cleared");
    do_lookup(48'h0000_0030_0000, "R9 fill discarded");

    // R7: random mix against the model
    for (int it = 0; it < 600; it++) begin
      int r = $urandom_range(0, 99);
      if (r < 25)
        do_fill(rnd_va(), PA_W'({$urandom(), $urandom()}), 8'($urandom()),
                $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom()), 0);
      else if (r < 27) do_inv();
      else begin
        int j = $urandom_range(0, N - 1);
        if (m_vld[j] && r < 85)
          do_lookup(m_va[j] | (rnd_va() & VA_W'(lowmask(m_sh[j]))), "R7 random hit");
        else
          do_lookup(rnd_va(), "R7 random");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule